// File: doc/BRIEF.md
# Signed-Step Index Jump Unit

This unit runs the loop-control step of a processor: it keeps a small bank of index registers, adds a signed 8-bit step to one of them, and picks the next location counter. There are two jump forms. The plain form always branches to the resolved target. The test form branches only when the sign of the updated index differs from the sign of the step. When the two signs match, it falls through to the next sequential location.

A third operation loads an index register directly, so the bank can be preset before a loop. The zero, greater and less flags follow the index result of each jump, not any accumulator. The target arrives already resolved, and the selected index register plays no part in forming it. All outputs are registered and appear one clock after the request.

Top module: `ixj_unit`

## Requirements
- R1: After synchronous reset, every index register reads zero and all of o_valid, o_wb_en, o_next_loc and the three flags are zero.
- R2: Op code 1 (load) writes i_target into register i_xsel. One cycle later it shows o_wb_en=1, o_wb_data=i_target and o_valid=0, and it leaves the flags unchanged.
- R3: Op codes 2 (plain jump) and 3 (test jump) write X+sext(i_step) back to register i_xsel. The sign bit of the step is i_step[7]. The result appears one cycle later on o_wb_data with o_wb_en=1 and o_wb_sel=i_xsel.
- R4: A plain jump sets o_next_loc to i_target exactly, whatever the index register holds, with o_valid=1.
- R5: A test jump sets o_next_loc to i_loc+1 (modulo 2^16) when the sign bit of the new index equals i_step[7], and to i_target otherwise. A zero result counts as positive.
- R6: After each jump, exactly one flag is set: Z when the result is zero, L when bit 15 is one, G otherwise. Cycles without a jump leave the flags unchanged.
- R7: The index addition wraps modulo 2^16 and raises no error indication.
- R8: Back-to-back operations on the same register see the value written by the previous operation.
- R9: With i_valid=0, the unit shows o_valid=0 and o_wb_en=0 and changes no index register, whatever the other inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_valid | input | 1 | Request present this cycle |
| i_op | input | 2 | 0 none, 1 load, 2 plain jump, 3 test jump |
| i_xsel | input | 3 | Index register select |
| i_step | input | 8 | Signed step, bit 7 is the sign |
| i_target | input | 16 | Resolved target address (load data for op 1) |
| i_loc | input | 16 | Current location counter |
| o_valid | output | 1 | Jump result valid |
| o_next_loc | output | 16 | Next location counter |
| o_wb_en | output | 1 | Index write-back performed |
| o_wb_sel | output | 3 | Written index register |
| o_wb_data | output | 16 | Written index value |
| o_flag_z | output | 1 | Index result zero |
| o_flag_g | output | 1 | Index result positive, non-zero |
| o_flag_l | output | 1 | Index result negative |

## Verification
The bench builds the unit with its default parameters: eight 16-bit index registers, an 8-bit step and a 16-bit address. At 16 bits the wrap from 0x7FFF into negative values and from 0xFFFF to zero is reached with a few steps near the edges. The count-up loop reaches zero and falls through, which exercises the rule that zero counts as positive. A count-down loop crosses zero and branches until the result turns negative. The location counter at 0xFFFF shows that the fall-through address wraps as well.

// File: rtl/ixj_pkg.sv
package ixj_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_LOAD = 2'd1,
    OP_XJ   = 2'd2,
    OP_XJT  = 2'd3
  } ixj_op_e;

  typedef struct packed {
    logic z;
    logic g;
    logic l;
  } ixj_flags_t;
endpackage

// File: rtl/ixj_regbank.sv
module ixj_regbank #(
  parameter int NREG = 8,
  parameter int XW   = 16,
  localparam int SW_SEL = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [SW_SEL-1:0] wsel,
  input  logic [XW-1:0]     wdata,
  input  logic [SW_SEL-1:0] rsel,
  output logic [XW-1:0]     rdata
);
  logic [XW-1:0] bank [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst)
        bank[g] <= '0;
      else if (we && (wsel == SW_SEL'(g)))
        bank[g] <= wdata;
    end
  end

  assign rdata = bank[rsel];
endmodule

// File: rtl/ixj_stepper.sv
module ixj_stepper #(
  parameter int XW = 16,
  parameter int SW = 8,
  parameter int AW = 16,
  localparam int EXT = XW - SW
) (
  input  logic [XW-1:0] cur,
  input  logic [SW-1:0] step,
  input  logic          is_test,
  input  logic [AW-1:0] target,
  input  logic [AW-1:0] loc,
  output logic [XW-1:0] sum,
  output logic [AW-1:0] next_loc
);
  localparam logic [AW-1:0] ONE_A = AW'(1);
  logic [XW-1:0] step_ext;
  logic          same_sign;

  assign step_ext  = {{EXT{step[SW-1]}}, step};
  assign sum       = cur + step_ext;
  assign same_sign = (sum[XW-1] == step[SW-1]);

  always_comb begin
    if (is_test && same_sign)
      next_loc = loc + ONE_A;
    else
      next_loc = target;
  end
endmodule

// File: rtl/ixj_flaggen.sv
module ixj_flaggen
  import ixj_pkg::*;
#(
  parameter int XW = 16
) (
  input  logic [XW-1:0] value,
  output ixj_flags_t    flags
);
  always_comb begin
    flags.z = (value == '0);
    flags.l = value[XW-1];
    flags.g = !value[XW-1] && (value != '0);
  end
endmodule

// File: rtl/ixj_unit.sv
module ixj_unit
  import ixj_pkg::*;
#(
  parameter int NREG = 8,
  parameter int XW   = 16,
  parameter int SW   = 8,
  parameter int AW   = 16,
  localparam int SELW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            i_valid,
  input  logic [1:0]      i_op,
  input  logic [SELW-1:0] i_xsel,
  input  logic [SW-1:0]   i_step,
  input  logic [AW-1:0]   i_target,
  input  logic [AW-1:0]   i_loc,
  output logic            o_valid,
  output logic [AW-1:0]   o_next_loc,
  output logic            o_wb_en,
  output logic [SELW-1:0] o_wb_sel,
  output logic [XW-1:0]   o_wb_data,
  output logic            o_flag_z,
  output logic            o_flag_g,
  output logic            o_flag_l
);
  localparam logic [AW-1:0] ONE_A = AW'(1);

  ixj_op_e       op;
  logic          is_jump, is_load, do_write;
  logic [XW-1:0] cur, sum, wdata;
  logic [AW-1:0] next_loc;
  ixj_flags_t    fl_new, fl_q;

  assign op       = ixj_op_e'(i_op);
  assign is_jump  = i_valid && (op == OP_XJ || op == OP_XJT);
  assign is_load  = i_valid && (op == OP_LOAD);
  assign do_write = is_jump || is_load;
  assign wdata    = is_load ? XW'(i_target) : sum;

  ixj_regbank #(.NREG(NREG), .XW(XW)) u_bank (
    .clk(clk), .rst(rst), .we(do_write), .wsel(i_xsel),
    .wdata(wdata), .rsel(i_xsel), .rdata(cur)
  );

  ixj_stepper #(.XW(XW), .SW(SW), .AW(AW)) u_step (
    .cur(cur), .step(i_step), .is_test(op == OP_XJT),
    .target(i_target), .loc(i_loc), .sum(sum), .next_loc(next_loc)
  );

  ixj_flaggen #(.XW(XW)) u_flag (.value(sum), .flags(fl_new));

  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid    <= 1'b0;
      o_next_loc <= '0;
      o_wb_en    <= 1'b0;
      o_wb_sel   <= '0;
      o_wb_data  <= '0;
      fl_q       <= '0;
    end else begin
      o_valid <= is_jump;
      o_wb_en <= do_write;
      if (is_jump) begin
        o_next_loc <= next_loc;
        fl_q       <= fl_new;
      end
      if (do_write) begin
        o_wb_sel  <= i_xsel;
        o_wb_data <= wdata;
      end
    end
  end

  assign o_flag_z = fl_q.z;
  assign o_flag_g = fl_q.g;
  assign o_flag_l = fl_q.l;

  // R6: one flag after any jump
  p_one_flag_r6: assert property (@(posedge clk) disable iff (rst)
    o_valid |-> ($countones({o_flag_z, o_flag_g, o_flag_l}) == 1));

  // R6: flags hold without a jump
  p_flags_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !is_jump |=> $stable({o_flag_z, o_flag_g, o_flag_l}));

  // R4: plain jump goes to the target
  p_xj_target_r4: assert property (@(posedge clk) disable iff (rst)
    (i_valid && i_op == 2'd2) |=> (o_valid && o_next_loc == $past(i_target)));

  // R5: test jump lands on target or the next location
  p_xjt_dest_r5: assert property (@(posedge clk) disable iff (rst)
    (i_valid && i_op == 2'd3) |=>
      (o_next_loc == $past(i_target) || o_next_loc == $past(i_loc) + ONE_A));

  // R3: write-back goes to the selected register
  p_wb_sel_r3: assert property (@(posedge clk) disable iff (rst)
    (i_valid && i_op != 2'd0) |=> (o_wb_en && o_wb_sel == $past(i_xsel)));

  // R9: idle cycles produce nothing
  p_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !i_valid |=> (!o_valid && !o_wb_en));

  // R2: load is not a jump
  p_load_nojump_r2: assert property (@(posedge clk) disable iff (rst)
    (i_valid && i_op == 2'd1) |=> !o_valid);
endmodule

// File: tb/ixj_unit_tb.sv
module ixj_unit_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        i_valid;
  logic [1:0]  i_op;
  logic [2:0]  i_xsel;
  logic [7:0]  i_step;
  logic [15:0] i_target, i_loc;
  logic        o_valid, o_wb_en, o_flag_z, o_flag_g, o_flag_l;
  logic [15:0] o_next_loc, o_wb_data;
  logic [2:0]  o_wb_sel;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  ixj_unit u_dut (
    .clk(clk), .rst(rst), .i_valid(i_valid), .i_op(i_op), .i_xsel(i_xsel),
    .i_step(i_step), .i_target(i_target), .i_loc(i_loc),
    .o_valid(o_valid), .o_next_loc(o_next_loc), .o_wb_en(o_wb_en),
    .o_wb_sel(o_wb_sel), .o_wb_data(o_wb_data),
    .o_flag_z(o_flag_z), .o_flag_g(o_flag_g), .o_flag_l(o_flag_l)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] sext(input logic [7:0] s);
    return {{8{s[7]}}, s};
  endfunction

  function automatic logic [2:0] flags_of(input logic [15:0] v);
    return {v == 16'd0, !v[15] && v != 16'd0, v[15]};
  endfunction

  task automatic drive(input logic [1:0] op, input logic [2:0] sel,
                       input logic [7:0] st, input logic [15:0] tgt,
                       input logic [15:0] loc);
    @(negedge clk);
    i_valid = 1'b1; i_op = op; i_xsel = sel; i_step = st;
    i_target = tgt; i_loc = loc;
  endtask

  task automatic idle();
    @(negedge clk);
    i_valid = 1'b0;
  endtask

  task automatic load_reg(input logic [2:0] sel, input logic [15:0] v);
    drive(2'd1, sel, 8'd0, v, 16'd0);
    idle();
  endtask

  // one jump, checked against the model; returns the new index value
  task automatic jump_chk(input string req, input logic [1:0] op,
                          input logic [2:0] sel, input logic [7:0] st,
                          input logic [15:0] tgt, input logic [15:0] loc,
                          inout logic [15:0] model);
    logic [15:0] nv, nl;
    nv = model + sext(st);
    if (op == 2'd3 && nv[15] == st[7]) nl = loc + 16'd1;
    else nl = tgt;
    drive(op, sel, st, tgt, loc);
    idle();
    chk(req, "valid", o_valid, 1);
    chk(req, "wb_data", o_wb_data, nv);
    chk(req, "next_loc", o_next_loc, nl);
    chk(req, "flags", {o_flag_z, o_flag_g, o_flag_l}, flags_of(nv));
    model = nv;
  endtask

  task automatic t_reset();
    logic [15:0] m;
    chk("R1", "valid", o_valid, 0);
    chk("R1", "wb_en", o_wb_en, 0);
    chk("R1", "next_loc", o_next_loc, 0);
    chk("R1", "flags", {o_flag_z, o_flag_g, o_flag_l}, 0);
    m = 16'd0;
    jump_chk("R1", 2'd2, 3'd6, 8'd0, 16'h0010, 16'h0000, m);
  endtask

  task automatic t_load();
    logic [15:0] m;
    logic [2:0]  fl;
    fl = {o_flag_z, o_flag_g, o_flag_l};
    drive(2'd1, 3'd3, 8'd0, 16'd100, 16'd0);
    idle();
    chk("R2", "wb_en", o_wb_en, 1);
    chk("R2", "wb_data", o_wb_data, 16'd100);
    chk("R2", "valid", o_valid, 0);
    chk("R2", "flags kept", {o_flag_z, o_flag_g, o_flag_l}, fl);
    m = 16'd100;
    jump_chk("R3", 2'd2, 3'd3, 8'hFB, 16'h1234, 16'h0200, m);
    chk("R3", "wb_sel", o_wb_sel, 3'd3);
    chk("R4", "target exact", o_next_loc, 16'h1234);
  endtask

  task automatic t_count_up();
    logic [15:0] m;
    load_reg(3'd2, 16'hFFFD);
    m = 16'hFFFD;
    for (int k = 0; k < 3; k++)
      jump_chk("R5", 2'd3, 3'd2, 8'h01, 16'h0040, 16'h0050, m);
    chk("R5", "zero falls through", o_next_loc, 16'h0051);
  endtask

  task automatic t_count_down();
    logic [15:0] m;
    load_reg(3'd5, 16'd2);
    m = 16'd2;
    for (int k = 0; k < 3; k++)
      jump_chk("R5", 2'd3, 3'd5, 8'hFF, 16'h0300, 16'h0400, m);
    chk("R6", "negative sets L", o_flag_l, 1);
    load_reg(3'd4, 16'hFFFF);
    m = 16'hFFFF;
    jump_chk("R5", 2'd3, 3'd4, 8'h80, 16'h0111, 16'hFFFF, m);
    chk("R5", "loc wraps", o_next_loc, 16'h0000);
  endtask

  task automatic t_wrap();
    logic [15:0] m;
    load_reg(3'd0, 16'h7FF0);
    m = 16'h7FF0;
    jump_chk("R7", 2'd2, 3'd0, 8'h7F, 16'h0099, 16'h0001, m);
    chk("R7", "wrapped value", o_wb_data, 16'h806F);
    load_reg(3'd0, 16'hFFFF);
    m = 16'hFFFF;
    jump_chk("R7", 2'd2, 3'd0, 8'h01, 16'h0099, 16'h0001, m);
    chk("R6", "zero sets Z", o_flag_z, 1);
  endtask

  task automatic t_b2b();
    load_reg(3'd1, 16'd10);
    drive(2'd2, 3'd1, 8'd5, 16'h0A00, 16'h0001);
    drive(2'd2, 3'd1, 8'd7, 16'h0B00, 16'h0002);
    chk("R8", "first", o_wb_data, 16'd15);
    idle();
    chk("R8", "second sees first", o_wb_data, 16'd22);
    chk("R8", "second target", o_next_loc, 16'h0B00);
  endtask

  task automatic t_idle();
    logic [15:0] m;
    logic [2:0]  fl;
    fl = {o_flag_z, o_flag_g, o_flag_l};
    @(negedge clk);
    i_valid = 1'b0; i_op = 2'd2; i_xsel = 3'd1; i_step = 8'd50;
    i_target = 16'h0777; i_loc = 16'h0;
    @(negedge clk);
    chk("R9", "valid", o_valid, 0);
    chk("R9", "wb_en", o_wb_en, 0);
    chk("R9", "flags kept", {o_flag_z, o_flag_g, o_flag_l}, fl);
    m = 16'd22;
    jump_chk("R9", 2'd2, 3'd1, 8'd0, 16'h0001, 16'h0, m);
  endtask

  initial begin
    #1000000;
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1; i_valid = 1'b0; i_op = 2'd0; i_xsel = 3'd0;
    i_step = 8'd0; i_target = 16'd0; i_loc = 16'd0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_load();
    t_count_up();
    t_count_down();
    t_wrap();
    t_b2b();
    t_idle();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule